// File: doc/BRIEF.md
# IO Channel Freeze/Thaw Sequencer

This block moves one high-speed IO channel between a frozen state and a thawed state. It drives the pad controls in a fixed order, together with four supporting controls: a regulator reset, a termination reset, a termination-calibration enable and a DLL restart. Pad controls must not move while the IO supply or the termination circuit is being reconfigured. The block therefore interleaves every reset and calibration edge with the pad edges and enforces minimum gaps between them.

Short gaps are counted in system clock cycles, set by parameters. The two long waits are counted in ticks of a slow oscillator. A tick is a one-cycle enable pulse synchronous to `clk`. The long waits are the calibration wait (`CAL_TICKS`) and the settle wait after termination release (`SETTLE_TICKS`).

A one-cycle `freeze_req` starts a freeze from the thawed idle state, and `thaw_req` starts a thaw from the frozen idle state. `busy` is high for the length of a sequence. `frozen` changes only when a sequence completes.

States:
- `ST_FROZEN` is the frozen idle state. It moves to `ST_TH_DLL` on `thaw_req`.
- The thaw path runs `ST_TH_DLL` → `ST_TH_W1` → `ST_TH_CAL` → `ST_TH_W2` → `ST_TH_BUS` → `ST_TH_W3` → `ST_TH_PAD` → `ST_TH_W4` → `ST_TH_REG` → `ST_TH_W5` → `ST_TH_SLEW` → `ST_THAWED`.
- `ST_THAWED` is the thawed idle state. It moves to `ST_FZ_PAD` on `freeze_req`.
- The freeze path runs `ST_FZ_PAD` → `ST_FZ_W1` → `ST_FZ_HOLD` → `ST_FZ_CAL` → `ST_FROZEN`.
- Each `W` state waits for the timer to reach zero before it moves on. Every other non-idle state is a one-cycle step that applies one group of control changes.

Top module: `iofrz_seq`

## Requirements
The control vector named below is {pad_slew_lo_n, pad_pull_n, pad_hiz_n, pad_hold_n, cfg_ready, vreg_rst, term_rst, term_cal_en, dll_restart}, with the first bit as the most significant.

- R1: Reset puts the outputs in the following state:
  - the control vector is 9'b000_00_11_01 (the frozen vector);
  - `frozen` is 1 and `busy` is 0.
- R2: A freeze goes through three vectors in this order:
  - 000_11_00_10 (slew, pull-up and tristate asserted);
  - 000_00_11_10, which comes at least `SHORT_CYC` cycles after the first (hold asserted, cfg_ready cleared, both resets asserted);
  - 000_00_11_01 (calibration disabled, DLL restart asserted).
- R3: The first thaw step gives vector 000_00_11_00 (DLL restart released). The second gives 000_00_11_10 (calibration enabled), at least `LONG_CYC` cycles later.
- R4: After the calibration enable, the next change comes no earlier than `CAL_TICKS` oscillator ticks. It gives vector 000_11_10_10: hold released, cfg_ready set and termination reset released.
- R5: After that change, the next change comes no earlier than `SETTLE_TICKS` ticks. It gives vector 011_11_10_10: pull-up and tristate released.
- R6: After at least `LONG_CYC` cycles, the regulator reset is released (vector 011_11_00_10). After at least `LONG_CYC` more cycles, slew is released (vector 111_11_00_10, the thawed vector).
- R7: `busy` is 1 from the cycle after an accepted request until the cycle after the last step. `frozen` changes only in the cycle where `busy` falls.
- R8: A request is ignored in two cases, and leaves the control vector unchanged:
  - when `busy` is 1;
  - when the channel is already in the requested state.
- R9: The tick waits advance only on `osc_tick` pulses. With no ticks, a thaw stays at the calibration-enabled vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| osc_tick | input | 1 | One-cycle oscillator tick enable |
| freeze_req | input | 1 | Start a freeze sequence |
| thaw_req | input | 1 | Start a thaw sequence |
| pad_slew_lo_n | output | 1 | Active-low slew control |
| pad_pull_n | output | 1 | Active-low weak pull-up control |
| pad_hiz_n | output | 1 | Active-low tristate control |
| pad_hold_n | output | 1 | Active-low bus-hold control |
| cfg_ready | output | 1 | Configuration-done, active high |
| vreg_rst | output | 1 | Regulator reset, active high |
| term_rst | output | 1 | Termination reset, active high |
| term_cal_en | output | 1 | Termination calibration start/enable |
| dll_restart | output | 1 | DLL reinit, active high |
| busy | output | 1 | Sequence in progress |
| frozen | output | 1 | Channel frozen status |

## Verification
Some internal faults show up at the very next change of the control vector:
- a step taken out of turn;
- a state that skips a wait;
- a wrong action in a step.

Such a fault produces a vector that differs from the one expected next, or a change that arrives earlier than its minimum cycle or tick spacing. A timer that loads the wrong count or ignores the tick gate moves the next edge outside its tick window, so the error is visible within one wait. A stuck state shows as `busy` staying high with an unchanged vector. A flag updated at the wrong time shows as `frozen` changing while `busy` stays steady.

// File: rtl/iofrz_pkg.sv
package iofrz_pkg;

    typedef enum logic [4:0] {
        ST_FROZEN,
        ST_TH_DLL,
        ST_TH_W1,
        ST_TH_CAL,
        ST_TH_W2,
        ST_TH_BUS,
        ST_TH_W3,
        ST_TH_PAD,
        ST_TH_W4,
        ST_TH_REG,
        ST_TH_W5,
        ST_TH_SLEW,
        ST_THAWED,
        ST_FZ_PAD,
        ST_FZ_W1,
        ST_FZ_HOLD,
        ST_FZ_CAL
    } seq_state_t;

    typedef struct packed {
        logic slew_lo_n;
        logic pull_n;
        logic hiz_n;
        logic hold_n;
        logic cfg_ready;
        logic vreg_rst;
        logic term_rst;
        logic cal_en;
        logic dll_restart;
    } pad_ctl_t;

    localparam pad_ctl_t CTL_FROZEN = '{
        slew_lo_n:   1'b0,
        pull_n:      1'b0,
        hiz_n:       1'b0,
        hold_n:      1'b0,
        cfg_ready:   1'b0,
        vreg_rst:    1'b1,
        term_rst:    1'b1,
        cal_en:      1'b0,
        dll_restart: 1'b1
    };

endpackage

// File: rtl/iofrz_timer.sv
module iofrz_timer #(
    parameter int CNT_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             use_tick,
    input  logic [CNT_W-1:0] load_val,
    input  logic             tick,
    output logic             done
);

    logic [CNT_W-1:0] cnt_q;
    logic             tick_mode_q;
    logic             advance;

    // Cycle mode counts every clock; tick mode counts only oscillator pulses.
    assign advance = (cnt_q != '0) && (!tick_mode_q || tick);
    assign done    = (cnt_q == '0);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q       <= '0;
            tick_mode_q <= 1'b0;
        end else if (load) begin
            cnt_q       <= load_val;
            tick_mode_q <= use_tick;
        end else if (advance) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/iofrz_fsm.sv
module iofrz_fsm
    import iofrz_pkg::*;
#(
    parameter int SHORT_CYC    = 4,
    parameter int LONG_CYC     = 8,
    parameter int CAL_TICKS    = 1000,
    parameter int SETTLE_TICKS = 33,
    parameter int CNT_W        = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             freeze_req,
    input  logic             thaw_req,
    input  logic             tmr_done,
    output seq_state_t       state,
    output logic             tmr_load,
    output logic             tmr_use_tick,
    output logic [CNT_W-1:0] tmr_val
);

    localparam logic [CNT_W-1:0] SHORT_V  = CNT_W'(SHORT_CYC);
    localparam logic [CNT_W-1:0] LONG_V   = CNT_W'(LONG_CYC);
    localparam logic [CNT_W-1:0] CAL_V    = CNT_W'(CAL_TICKS);
    localparam logic [CNT_W-1:0] SETTLE_V = CNT_W'(SETTLE_TICKS);

    seq_state_t state_q, state_d;

    assign state = state_q;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_FROZEN;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FROZEN:  if (thaw_req)   state_d = ST_TH_DLL;
            ST_TH_DLL:  state_d = ST_TH_W1;
            ST_TH_W1:   if (tmr_done)   state_d = ST_TH_CAL;
            ST_TH_CAL:  state_d = ST_TH_W2;
            ST_TH_W2:   if (tmr_done)   state_d = ST_TH_BUS;
            ST_TH_BUS:  state_d = ST_TH_W3;
            ST_TH_W3:   if (tmr_done)   state_d = ST_TH_PAD;
            ST_TH_PAD:  state_d = ST_TH_W4;
            ST_TH_W4:   if (tmr_done)   state_d = ST_TH_REG;
            ST_TH_REG:  state_d = ST_TH_W5;
            ST_TH_W5:   if (tmr_done)   state_d = ST_TH_SLEW;
            ST_TH_SLEW: state_d = ST_THAWED;
            ST_THAWED:  if (freeze_req) state_d = ST_FZ_PAD;
            ST_FZ_PAD:  state_d = ST_FZ_W1;
            ST_FZ_W1:   if (tmr_done)   state_d = ST_FZ_HOLD;
            ST_FZ_HOLD: state_d = ST_FZ_CAL;
            ST_FZ_CAL:  state_d = ST_FROZEN;
            default:    state_d = ST_FROZEN;
        endcase
    end

    // Timer control: each step that opens a wait loads the timer for it.
    always_comb begin
        tmr_load     = 1'b0;
        tmr_use_tick = 1'b0;
        tmr_val      = '0;
        unique case (state_q)
            ST_FZ_PAD: begin
                tmr_load = 1'b1;
                tmr_val  = SHORT_V;
            end
            ST_TH_DLL, ST_TH_PAD, ST_TH_REG: begin
                tmr_load = 1'b1;
                tmr_val  = LONG_V;
            end
            ST_TH_CAL: begin
                tmr_load     = 1'b1;
                tmr_use_tick = 1'b1;
                tmr_val      = CAL_V;
            end
            ST_TH_BUS: begin
                tmr_load     = 1'b1;
                tmr_use_tick = 1'b1;
                tmr_val      = SETTLE_V;
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/iofrz_drive.sv
module iofrz_drive
    import iofrz_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  seq_state_t state,
    output pad_ctl_t   ctl,
    output logic       frozen,
    output logic       busy
);

    pad_ctl_t ctl_q;
    logic     frozen_q;

    assign ctl    = ctl_q;
    assign frozen = frozen_q;
    assign busy   = (state != ST_FROZEN) && (state != ST_THAWED);

    // Output register: each step state applies its control group as it exits.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q    <= CTL_FROZEN;
            frozen_q <= 1'b1;
        end else begin
            unique case (state)
                ST_TH_DLL: begin
                    ctl_q.dll_restart <= 1'b0;
                end
                ST_TH_CAL: begin
                    ctl_q.cal_en <= 1'b1;
                end
                ST_TH_BUS: begin
                    ctl_q.hold_n    <= 1'b1;
                    ctl_q.cfg_ready <= 1'b1;
                    ctl_q.term_rst  <= 1'b0;
                end
                ST_TH_PAD: begin
                    ctl_q.pull_n <= 1'b1;
                    ctl_q.hiz_n  <= 1'b1;
                end
                ST_TH_REG: begin
                    ctl_q.vreg_rst <= 1'b0;
                end
                ST_TH_SLEW: begin
                    ctl_q.slew_lo_n <= 1'b1;
                    frozen_q        <= 1'b0;
                end
                ST_FZ_PAD: begin
                    ctl_q.slew_lo_n <= 1'b0;
                    ctl_q.pull_n    <= 1'b0;
                    ctl_q.hiz_n     <= 1'b0;
                end
                ST_FZ_HOLD: begin
                    ctl_q.hold_n    <= 1'b0;
                    ctl_q.cfg_ready <= 1'b0;
                    ctl_q.vreg_rst  <= 1'b1;
                    ctl_q.term_rst  <= 1'b1;
                end
                ST_FZ_CAL: begin
                    ctl_q.cal_en      <= 1'b0;
                    ctl_q.dll_restart <= 1'b1;
                    frozen_q          <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/iofrz_seq.sv
module iofrz_seq
    import iofrz_pkg::*;
#(
    parameter int SHORT_CYC    = 4,
    parameter int LONG_CYC     = 8,
    parameter int CAL_TICKS    = 1000,
    parameter int SETTLE_TICKS = 33
) (
    input  logic clk,
    input  logic rst_n,
    input  logic osc_tick,
    input  logic freeze_req,
    input  logic thaw_req,
    output logic pad_slew_lo_n,
    output logic pad_pull_n,
    output logic pad_hiz_n,
    output logic pad_hold_n,
    output logic cfg_ready,
    output logic vreg_rst,
    output logic term_rst,
    output logic term_cal_en,
    output logic dll_restart,
    output logic busy,
    output logic frozen
);

    localparam int MAX_A   = (SHORT_CYC > LONG_CYC) ? SHORT_CYC : LONG_CYC;
    localparam int MAX_B   = (CAL_TICKS > SETTLE_TICKS) ? CAL_TICKS : SETTLE_TICKS;
    localparam int MAX_CNT = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(MAX_CNT + 1);

    seq_state_t       state;
    logic             tmr_load;
    logic             tmr_use_tick;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_done;
    pad_ctl_t         ctl;

    iofrz_fsm #(
        .SHORT_CYC    (SHORT_CYC),
        .LONG_CYC     (LONG_CYC),
        .CAL_TICKS    (CAL_TICKS),
        .SETTLE_TICKS (SETTLE_TICKS),
        .CNT_W        (CNT_W)
    ) fsm_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .freeze_req   (freeze_req),
        .thaw_req     (thaw_req),
        .tmr_done     (tmr_done),
        .state        (state),
        .tmr_load     (tmr_load),
        .tmr_use_tick (tmr_use_tick),
        .tmr_val      (tmr_val)
    );

    iofrz_timer #(
        .CNT_W (CNT_W)
    ) timer_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .use_tick (tmr_use_tick),
        .load_val (tmr_val),
        .tick     (osc_tick),
        .done     (tmr_done)
    );

    iofrz_drive drive_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .state  (state),
        .ctl    (ctl),
        .frozen (frozen),
        .busy   (busy)
    );

    assign pad_slew_lo_n = ctl.slew_lo_n;
    assign pad_pull_n    = ctl.pull_n;
    assign pad_hiz_n     = ctl.hiz_n;
    assign pad_hold_n    = ctl.hold_n;
    assign cfg_ready     = ctl.cfg_ready;
    assign vreg_rst      = ctl.vreg_rst;
    assign term_rst      = ctl.term_rst;
    assign term_cal_en   = ctl.cal_en;
    assign dll_restart   = ctl.dll_restart;

endmodule

// File: rtl/iofrz_chk.sv
module iofrz_chk (
    input logic clk,
    input logic rst_n,
    input logic pad_slew_lo_n,
    input logic pad_pull_n,
    input logic pad_hiz_n,
    input logic pad_hold_n,
    input logic cfg_ready,
    input logic vreg_rst,
    input logic term_rst,
    input logic term_cal_en,
    input logic dll_restart,
    input logic busy,
    input logic frozen
);

    logic [8:0] vec;
    assign vec = {pad_slew_lo_n, pad_pull_n, pad_hiz_n, pad_hold_n, cfg_ready,
                  vreg_rst, term_rst, term_cal_en, dll_restart};

    // R1: frozen idle holds the full frozen vector
    p_frozen_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (frozen && !busy) |-> (vec == 9'b000_00_11_01));

    // R2: resets only rise once the pads are already clamped
    p_pads_before_rst_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vreg_rst) |-> (!pad_slew_lo_n && !pad_pull_n && !pad_hiz_n));

    // R3: calibration only starts with the DLL restart released
    p_dll_before_cal_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(term_cal_en) |-> !dll_restart);

    // R4: termination reset released together with hold and cfg_ready
    p_term_release_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(term_rst) |-> (term_cal_en && cfg_ready && pad_hold_n));

    // R5: pull-up released only after termination reset is gone
    p_pull_after_term_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_pull_n) |-> (!term_rst && cfg_ready));

    // R6: slew released last
    p_slew_last_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pad_slew_lo_n) |-> (!vreg_rst && pad_pull_n && pad_hiz_n && cfg_ready));

    // R7: status flag moves only as a sequence ends
    p_flag_on_end_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(frozen) |-> $fell(busy));

    // R8: controls stay put while idle
    p_idle_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && $past(!busy)) |-> $stable(vec));

endmodule

bind iofrz_seq iofrz_chk chk_i (.*);

// File: tb/iofrz_seq_tb_top.sv
`timescale 1ns/1ps
module iofrz_seq_tb_top;

    localparam int SHORT_CYC    = 4;
    localparam int LONG_CYC     = 8;
    localparam int CAL_TICKS    = 1000;
    localparam int SETTLE_TICKS = 33;

    localparam logic [8:0] V_FROZEN = 9'b000_00_11_01;
    localparam logic [8:0] V_T1     = 9'b000_00_11_00;
    localparam logic [8:0] V_T2     = 9'b000_00_11_10;
    localparam logic [8:0] V_T3     = 9'b000_11_10_10;
    localparam logic [8:0] V_T4     = 9'b011_11_10_10;
    localparam logic [8:0] V_T5     = 9'b011_11_00_10;
    localparam logic [8:0] V_THAWED = 9'b111_11_00_10;
    localparam logic [8:0] V_F1     = 9'b000_11_00_10;
    localparam logic [8:0] V_F2     = 9'b000_00_11_10;

    typedef struct packed {
        logic [8:0]  vec;
        logic [31:0] min_cyc;
        logic [31:0] tmin;
        logic [31:0] tmax;
    } exp_t;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic osc_tick = 1'b0;
    logic freeze_req = 1'b0;
    logic thaw_req = 1'b0;
    logic pad_slew_lo_n, pad_pull_n, pad_hiz_n, pad_hold_n, cfg_ready;
    logic vreg_rst, term_rst, term_cal_en, dll_restart, busy, frozen;

    int   errors = 0;
    int   checks = 0;
    logic tick_en = 1'b1;
    logic [1:0] div = '0;
    int   cyc = 0;
    int   tick_cnt = 0;
    logic mon_on = 1'b0;
    logic [8:0] last_vec;
    int   last_cyc = 0;
    int   last_tick = 0;
    logic done_flag = 1'b0;

    exp_t  exp_q[$];
    string tag_q[$];

    always #2.5 clk = ~clk;

    iofrz_seq #(
        .SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC),
        .CAL_TICKS(CAL_TICKS), .SETTLE_TICKS(SETTLE_TICKS)
    ) dut_i (
        .clk(clk), .rst_n(rst_n), .osc_tick(osc_tick),
        .freeze_req(freeze_req), .thaw_req(thaw_req),
        .pad_slew_lo_n(pad_slew_lo_n), .pad_pull_n(pad_pull_n),
        .pad_hiz_n(pad_hiz_n), .pad_hold_n(pad_hold_n),
        .cfg_ready(cfg_ready), .vreg_rst(vreg_rst), .term_rst(term_rst),
        .term_cal_en(term_cal_en), .dll_restart(dll_restart),
        .busy(busy), .frozen(frozen)
    );

    function automatic logic [8:0] cur_vec();
        return {pad_slew_lo_n, pad_pull_n, pad_hiz_n, pad_hold_n, cfg_ready,
                vreg_rst, term_rst, term_cal_en, dll_restart};
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
        end
    endtask

    task automatic push_exp(input logic [8:0] v, input int min_cyc,
                            input int tmin, input int tmax, input string req);
        exp_t e;
        e.vec = v; e.min_cyc = min_cyc; e.tmin = tmin; e.tmax = tmax;
        exp_q.push_back(e);
        tag_q.push_back(req);
    endtask

    task automatic push_thaw();
        push_exp(V_T1, 1, 0, 32'hFFFF, "R3");
        push_exp(V_T2, LONG_CYC, 0, 32'hFFFF, "R3");
        push_exp(V_T3, 1, CAL_TICKS, CAL_TICKS + 2, "R4");
        push_exp(V_T4, 1, SETTLE_TICKS, SETTLE_TICKS + 2, "R5");
        push_exp(V_T5, LONG_CYC, 0, 32'hFFFF, "R6");
        push_exp(V_THAWED, LONG_CYC, 0, 32'hFFFF, "R6");
    endtask

    task automatic push_freeze();
        push_exp(V_F1, 1, 0, 32'hFFFF, "R2");
        push_exp(V_F2, SHORT_CYC, 0, 32'hFFFF, "R2");
        push_exp(V_FROZEN, 1, 0, 32'hFFFF, "R2");
    endtask

    task automatic pulse(input bit fz, input bit th);
        @(negedge clk);
        freeze_req = fz;
        thaw_req   = th;
        @(negedge clk);
        freeze_req = 1'b0;
        thaw_req   = 1'b0;
    endtask

    task automatic wait_idle();
        do @(negedge clk); while (busy || exp_q.size() != 0);
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Oscillator tick: one pulse every fourth cycle when enabled
    always @(negedge clk) begin
        if (tick_en) begin
            div      <= div + 1'b1;
            osc_tick <= (div == 2'd3);
        end else begin
            osc_tick <= 1'b0;
        end
    end

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (osc_tick) tick_cnt <= tick_cnt + 1;
    end

    // Monitor: every change of the control vector pops one expected item
    always @(negedge clk) begin
        if (mon_on && cur_vec() !== last_vec) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8", "unexpected control change", 32'(cur_vec()), 32'(last_vec));
            end else begin
                exp_t  e;
                string r;
                e = exp_q.pop_front();
                r = tag_q.pop_front();
                check(cur_vec() === e.vec, r, "control vector", 32'(cur_vec()), 32'(e.vec));
                check((cyc - last_cyc) >= int'(e.min_cyc), r, "cycle gap",
                      32'(cyc - last_cyc), e.min_cyc);
                check((tick_cnt - last_tick) >= int'(e.tmin) &&
                      (tick_cnt - last_tick) <= int'(e.tmax), r, "tick gap",
                      32'(tick_cnt - last_tick), e.tmin);
            end
            last_vec  = cur_vec();
            last_cyc  = cyc;
            last_tick = tick_cnt;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done_flag) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (4) @(negedge clk);
        // R1 reset state
        check(cur_vec() === V_FROZEN, "R1", "reset vector", 32'(cur_vec()), 32'(V_FROZEN));
        check(frozen === 1'b1, "R1", "reset frozen", 32'(frozen), 1);
        check(busy === 1'b0, "R1", "reset busy", 32'(busy), 0);
        rst_n = 1'b1;
        last_vec = V_FROZEN;
        mon_on = 1'b1;

        // R8: freeze while already frozen is ignored
        pulse(1'b1, 1'b0);
        repeat (20) @(negedge clk);
        check(busy === 1'b0, "R8", "freeze when frozen busy", 32'(busy), 0);
        check(cur_vec() === V_FROZEN, "R8", "freeze when frozen vector", 32'(cur_vec()), 32'(V_FROZEN));

        // Thaw with a freeze request injected while busy (R8) and a tick stall (R9)
        push_thaw();
        pulse(1'b0, 1'b1);
        check(busy === 1'b1, "R7", "busy after thaw request", 32'(busy), 1);
        check(frozen === 1'b1, "R7", "flag held during thaw", 32'(frozen), 1);
        repeat (3) @(negedge clk);
        pulse(1'b1, 1'b0);
        do @(negedge clk); while (cur_vec() !== V_T2);
        tick_en = 1'b0;
        repeat (3000) @(negedge clk);
        check(cur_vec() === V_T2, "R9", "stalled without ticks", 32'(cur_vec()), 32'(V_T2));
        check(busy === 1'b1, "R9", "busy while stalled", 32'(busy), 1);
        tick_en = 1'b1;
        wait_idle();
        check(frozen === 1'b0, "R7", "flag after thaw", 32'(frozen), 0);
        check(cur_vec() === V_THAWED, "R6", "thawed vector", 32'(cur_vec()), 32'(V_THAWED));

        // R8: thaw while thawed is ignored
        pulse(1'b0, 1'b1);
        repeat (30) @(negedge clk);
        check(busy === 1'b0, "R8", "thaw when thawed busy", 32'(busy), 0);
        check(cur_vec() === V_THAWED, "R8", "thaw when thawed vector", 32'(cur_vec()), 32'(V_THAWED));

        // Freeze with a thaw request injected while busy
        push_freeze();
        pulse(1'b1, 1'b0);
        check(busy === 1'b1, "R7", "busy after freeze request", 32'(busy), 1);
        check(frozen === 1'b0, "R7", "flag held during freeze", 32'(frozen), 0);
        pulse(1'b0, 1'b1);
        wait_idle();
        check(frozen === 1'b1, "R7", "flag after freeze", 32'(frozen), 1);
        check(cur_vec() === V_FROZEN, "R2", "frozen vector", 32'(cur_vec()), 32'(V_FROZEN));

        // Both requests together while frozen: only the thaw applies
        push_thaw();
        pulse(1'b1, 1'b1);
        wait_idle();
        check(frozen === 1'b0, "R8", "both requests from frozen", 32'(frozen), 0);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, "R8", "no leftover expectations", 32'(exp_q.size()), 0);

        done_flag = 1'b1;
        summary();
        $finish;
    end

endmodule